// File: doc/BRIEF.md
# Word ALU with Registered Condition Flag

This block is the execute stage of a small register machine. Each cycle it takes an opcode, two W-bit operands (the source register `src_j` and the second operand `src_a`, which may come from a register or an immediate) and the current value of the destination register. From these it produces a W-bit result, a write-enable for the register file and the next value of a one-bit condition flag. Each operation has its own rule for the flag. Logic operations test for a zero result. Add reports the carry and subtract reports a borrow. Multiplies report a product that does not fit in W bits, and shifts report the edge bit of the source. Compares change only the flag, while the moves read the flag and leave it as it is.

The flag register is inside the block and is loaded from `flag_next` on a clock edge where `instr_valid` is high. The datapath is combinational, so an instruction presented in one cycle sees the flag left by the instruction before it. There is no back-pressure. The block accepts an instruction in every cycle where the strobe is high, and `wr_en` is only asserted in such a cycle. Division, memory access, input reads and program-counter logic belong to other blocks.

Top module: `flagged_alu`

## Requirements
- R1: Opcodes 0 (and), 1 (or) and 2 (xor) write the bitwise combination of `src_j` and `src_a`. Opcode 3 (not) writes `~src_a`. For all four, `flag_next` is 1 exactly when the written result is all zeros.
- R2: Opcode 4 (add) writes the low W bits of `src_j + src_a`, and `flag_next` is the carry out of bit W-1.
- R3: Opcode 5 (sub) writes `src_j - src_a` modulo 2^W. `flag_next` is 1 exactly when `src_j < src_a` as unsigned values.
- R4: Opcode 6 writes the low W bits of the unsigned 2W-bit product, and opcode 7 writes its high W bits. For both, `flag_next` is 1 when that product is 2^W or more.
- R5: Opcode 8 writes the upper W bits of the 2W-bit two's-complement product of the signed operands. `flag_next` is 1 when the product lies outside -2^(W-1) .. 2^(W-1)-1.
- R6: Opcode 9 shifts `src_j` left and opcode 10 shifts it right, both by the unsigned value of `src_a` and both with zero fill. An amount of W or more gives 0. `flag_next` is `src_j[W-1]` for the left shift and `src_j[0]` for the right shift.
- R7: Opcodes 11 to 15 are the compares. `flag_next` is 1 when `src_j` and `src_a` are equal (11), unsigned greater (12), unsigned greater-or-equal (13), signed greater (14) or signed greater-or-equal (15). These opcodes keep `wr_en` low and drive `result` to 0.
- R8: Opcode 16 (mov) writes `src_a`. Opcode 17 (cmov) writes `src_a` when `flag_q` is 1 and writes `dest_val` when it is 0. Both keep `flag_next` equal to `flag_q`.
- R9: `flag_q` is 0 after reset. On each rising clock edge it takes `flag_next` if `instr_valid` is high, and otherwise holds its value.
- R10: `wr_en` is high only when `instr_valid` is high and the opcode writes a register. Opcodes 18 to 31 give a result of 0 and a low `wr_en`, and keep `flag_next` equal to `flag_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present this cycle; enables the flag load |
| opcode | input | 5 | Operation code |
| src_j | input | W | First operand |
| src_a | input | W | Second operand (register or immediate) |
| dest_val | input | W | Current destination register value |
| result | output | W | Value to write back |
| wr_en | output | 1 | Write-enable for the destination register |
| flag_next | output | 1 | Flag value this instruction produces |
| flag_q | output | 1 | Current registered flag |

## Verification
An instruction can update the flag in the same clock edge at which the next instruction's conditional move reads it. Because of this, a flag update and a cmov that depends on it fall in back-to-back cycles. The bench provokes this by issuing compares and arithmetic whose flag outcome is chosen on purpose, and following each one directly with a cmov or mov. The cmov must select `src_a` or `dest_val` by the flag just written, and the mov must leave that flag unchanged. An idle cycle is also placed between a flag-setting operation and a move, to confirm that a strobe-less cycle loads nothing.

// File: rtl/flagged_alu_pkg.sv
package flagged_alu_pkg;
  typedef enum logic [4:0] {
    OP_AND   = 5'd0,
    OP_OR    = 5'd1,
    OP_XOR   = 5'd2,
    OP_NOT   = 5'd3,
    OP_ADD   = 5'd4,
    OP_SUB   = 5'd5,
    OP_MULL  = 5'd6,
    OP_UMULH = 5'd7,
    OP_SMULH = 5'd8,
    OP_SHL   = 5'd9,
    OP_SHR   = 5'd10,
    OP_CMPE  = 5'd11,
    OP_CMPA  = 5'd12,
    OP_CMPAE = 5'd13,
    OP_CMPG  = 5'd14,
    OP_CMPGE = 5'd15,
    OP_MOV   = 5'd16,
    OP_CMOV  = 5'd17
  } op_e;

  localparam int unsigned OP_W = 5;
endpackage

// File: rtl/flagged_alu_logic.sv
module flagged_alu_logic #(
  parameter int unsigned W = 16
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] opj,
  input  logic [W-1:0] opa,
  output logic [W-1:0] res,
  output logic         zero
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      unique case (sel)
        2'd0:    res[b] = opj[b] & opa[b];
        2'd1:    res[b] = opj[b] | opa[b];
        2'd2:    res[b] = opj[b] ^ opa[b];
        default: res[b] = ~opa[b];
      endcase
    end
  end

  assign zero = ~|res;
endmodule

// File: rtl/flagged_alu_arith.sv
module flagged_alu_arith #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] opj,
  input  logic [W-1:0] opa,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic [W-1:0] diff,
  output logic         borrow,
  output logic [W-1:0] mul_lo,
  output logic [W-1:0] mul_hi,
  output logic         mul_ovf,
  output logic [W-1:0] smul_hi,
  output logic         smul_ovf
);
  localparam int unsigned PW = 2 * W;

  logic [W:0]  add_full;
  logic [W:0]  sub_full;
  logic [PW-1:0] prod_u;
  logic signed [PW-1:0] prod_s;
  logic [W:0]  sign_span;

  assign add_full = {1'b0, opj} + {1'b0, opa};
  assign sum      = add_full[W-1:0];
  assign carry    = add_full[W];

  // 2^W + j - a: the top bit stays set unless a borrow occurs
  assign sub_full = {1'b1, opj} - {1'b0, opa};
  assign diff     = sub_full[W-1:0];
  assign borrow   = ~sub_full[W];

  assign prod_u  = {{W{1'b0}}, opj} * {{W{1'b0}}, opa};
  assign mul_lo  = prod_u[W-1:0];
  assign mul_hi  = prod_u[PW-1:W];
  assign mul_ovf = |prod_u[PW-1:W];

  assign prod_s    = $signed({{W{opj[W-1]}}, opj}) * $signed({{W{opa[W-1]}}, opa});
  assign smul_hi   = prod_s[PW-1:W];
  assign sign_span = prod_s[PW-1:W-1];
  assign smul_ovf  = ~((&sign_span) | ~(|sign_span));
endmodule

// File: rtl/flagged_alu_shcmp.sv
module flagged_alu_shcmp #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] opj,
  input  logic [W-1:0] opa,
  output logic [W-1:0] shl_res,
  output logic [W-1:0] shr_res,
  output logic         eq,
  output logic         ugt,
  output logic         uge,
  output logic         sgt,
  output logic         sge
);
  localparam int unsigned SHW = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0] W_LIMIT = W[W-1:0];

  logic           amt_big;
  logic [SHW-1:0] amt;

  assign amt_big = (opa >= W_LIMIT);
  assign amt     = opa[SHW-1:0];

  assign shl_res = amt_big ? '0 : (opj << amt);
  assign shr_res = amt_big ? '0 : (opj >> amt);

  assign eq  = (opj == opa);
  assign ugt = (opj > opa);
  assign uge = ugt | eq;
  assign sgt = ($signed(opj) > $signed(opa));
  assign sge = sgt | eq;
endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
  import flagged_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [OP_W-1:0] opcode,
  input  logic [W-1:0]    src_j,
  input  logic [W-1:0]    src_a,
  input  logic [W-1:0]    dest_val,
  output logic [W-1:0]    result,
  output logic            wr_en,
  output logic            flag_next,
  output logic            flag_q
);
  op_e op;
  assign op = op_e'(opcode);

  logic [W-1:0] lg_res;
  logic         lg_zero;
  logic [W-1:0] ad_sum, sb_diff, m_lo, m_hi, sm_hi;
  logic         ad_c, sb_b, m_ovf, sm_ovf;
  logic [W-1:0] sh_l, sh_r;
  logic         c_eq, c_ugt, c_uge, c_sgt, c_sge;
  logic         writes;

  flagged_alu_logic #(.W(W)) u_logic (
    .sel  (opcode[1:0]),
    .opj  (src_j),
    .opa  (src_a),
    .res  (lg_res),
    .zero (lg_zero)
  );

  flagged_alu_arith #(.W(W)) u_arith (
    .opj      (src_j),
    .opa      (src_a),
    .sum      (ad_sum),
    .carry    (ad_c),
    .diff     (sb_diff),
    .borrow   (sb_b),
    .mul_lo   (m_lo),
    .mul_hi   (m_hi),
    .mul_ovf  (m_ovf),
    .smul_hi  (sm_hi),
    .smul_ovf (sm_ovf)
  );

  flagged_alu_shcmp #(.W(W)) u_shcmp (
    .opj     (src_j),
    .opa     (src_a),
    .shl_res (sh_l),
    .shr_res (sh_r),
    .eq      (c_eq),
    .ugt     (c_ugt),
    .uge     (c_uge),
    .sgt     (c_sgt),
    .sge     (c_sge)
  );

  always_comb begin
    result    = '0;
    flag_next = flag_q;
    writes    = 1'b1;
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin
        result    = lg_res;
        flag_next = lg_zero;
      end
      OP_ADD:   begin result = ad_sum;  flag_next = ad_c;   end
      OP_SUB:   begin result = sb_diff; flag_next = sb_b;   end
      OP_MULL:  begin result = m_lo;    flag_next = m_ovf;  end
      OP_UMULH: begin result = m_hi;    flag_next = m_ovf;  end
      OP_SMULH: begin result = sm_hi;   flag_next = sm_ovf; end
      OP_SHL:   begin result = sh_l;    flag_next = src_j[W-1]; end
      OP_SHR:   begin result = sh_r;    flag_next = src_j[0];   end
      OP_CMPE:  begin writes = 1'b0; flag_next = c_eq;  end
      OP_CMPA:  begin writes = 1'b0; flag_next = c_ugt; end
      OP_CMPAE: begin writes = 1'b0; flag_next = c_uge; end
      OP_CMPG:  begin writes = 1'b0; flag_next = c_sgt; end
      OP_CMPGE: begin writes = 1'b0; flag_next = c_sge; end
      OP_MOV:   result = src_a;
      OP_CMOV:  result = flag_q ? src_a : dest_val;
      default:  writes = 1'b0;
    endcase
  end

  assign wr_en = instr_valid & writes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag_q <= 1'b0;
    else if (instr_valid) flag_q <= flag_next;
  end
endmodule

// File: rtl/flagged_alu_chk.sv
module flagged_alu_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         instr_valid,
  input logic [4:0]   opcode,
  input logic [W-1:0] src_j,
  input logic [W-1:0] src_a,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic         flag_next,
  input logic         flag_q
);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(flag_q));

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> (flag_q == $past(flag_next)));

  a_r10_idle_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !wr_en);

  a_r7_cmp_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opcode >= 5'd11 && opcode <= 5'd15) |-> (!wr_en && result == '0));

  a_r8_move_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && (opcode == 5'd16 || opcode == 5'd17)) |-> (flag_next == flag_q));

  a_r1_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opcode <= 5'd3) |-> (flag_next == (result == '0)));

  a_r3_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opcode == 5'd5) |-> (flag_next == (src_j < src_a)));
endmodule

bind flagged_alu flagged_alu_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .opcode      (opcode),
  .src_j       (src_j),
  .src_a       (src_a),
  .result      (result),
  .wr_en       (wr_en),
  .flag_next   (flag_next),
  .flag_q      (flag_q)
);

// File: tb/flagged_alu_tb_top.sv
module flagged_alu_tb_top;
  localparam int unsigned W = 16;
  localparam longint MASK = (64'd1 << W) - 1;
  localparam longint HALF = 64'd1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         instr_valid = 1'b0;
  logic [4:0]   opcode = '0;
  logic [W-1:0] src_j = '0, src_a = '0, dest_val = '0;
  logic [W-1:0] result;
  logic         wr_en, flag_next, flag_q;

  always #5 clk = ~clk;

  flagged_alu #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
    .src_j(src_j), .src_a(src_a), .dest_val(dest_val),
    .result(result), .wr_en(wr_en), .flag_next(flag_next), .flag_q(flag_q)
  );

  typedef struct packed {
    logic [W-1:0] res;
    logic         wr;
    logic         fn;
    logic         fq;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad = 0;
  bit    model_flag = 1'b0;
  bit    finished = 1'b0;

  function automatic longint sx(longint v);
    return (v >= HALF) ? v - (64'd1 << W) : v;
  endfunction

  task automatic model(input int op, input longint j, input longint a, input longint d,
                       input bit f, output longint r, output bit w, output bit fo);
    longint p;
    r = 0; w = 1; fo = f;
    case (op)
      0: begin r = j & a; fo = (r == 0); end
      1: begin r = j | a; fo = (r == 0); end
      2: begin r = j ^ a; fo = (r == 0); end
      3: begin r = (~a) & MASK; fo = (r == 0); end
      4: begin p = j + a; r = p & MASK; fo = p[W]; end
      5: begin r = (j - a) & MASK; fo = (j < a); end
      6: begin p = j * a; r = p & MASK; fo = (p > MASK); end
      7: begin p = j * a; r = (p >> W) & MASK; fo = (p > MASK); end
      8: begin p = sx(j) * sx(a); r = (p >>> W) & MASK; fo = (p < -HALF) || (p > HALF - 1); end
      9: begin r = (a >= W) ? 0 : ((j << a) & MASK); fo = j[W-1]; end
      10: begin r = (a >= W) ? 0 : (j >> a); fo = j[0]; end
      11: begin w = 0; fo = (j == a); end
      12: begin w = 0; fo = (j > a); end
      13: begin w = 0; fo = (j >= a); end
      14: begin w = 0; fo = (sx(j) > sx(a)); end
      15: begin w = 0; fo = (sx(j) >= sx(a)); end
      16: r = a;
      17: r = f ? a : d;
      default: w = 0;
    endcase
  endtask

  task automatic issue(input bit v, input int op, input longint j, input longint a,
                       input longint d, input string tag);
    longint r; bit w, fo;
    exp_t e;
    @(negedge clk);
    instr_valid = v; opcode = op[4:0];
    src_j = j[W-1:0]; src_a = a[W-1:0]; dest_val = d[W-1:0];
    model(op, j & MASK, a & MASK, d & MASK, model_flag, r, w, fo);
    e.res = r[W-1:0]; e.wr = w & v; e.fn = fo; e.fq = model_flag;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (v) model_flag = fo;
  endtask

  // monitor: samples 2 ns after the falling edge, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e; string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (result !== e.res || wr_en !== e.wr || flag_next !== e.fn || flag_q !== e.fq) begin
          bad++;
          $display("FAIL %s: got res=%h wr=%b fn=%b fq=%b exp res=%h wr=%b fn=%b fq=%b",
                   t, result, wr_en, flag_next, flag_q, e.res, e.wr, e.fn, e.fq);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    total++;
    if (flag_q !== 1'b0 || wr_en !== 1'b0) begin
      bad++;
      $display("FAIL R9 reset: got fq=%b wr=%b exp fq=0 wr=0", flag_q, wr_en);
    end
    // R1 logic ops, including zero results
    issue(1, 0, 16'hF0F0, 16'h0F0F, 0, "R1 and zero");
    issue(1, 0, 16'hF0F0, 16'h3C3C, 0, "R1 and");
    issue(1, 1, 16'h0000, 16'h0000, 0, "R1 or zero");
    issue(1, 2, 16'hA5A5, 16'hA5A5, 0, "R1 xor zero");
    issue(1, 3, 0, 16'hFFFF, 0, "R1 not zero");
    issue(1, 3, 0, 16'h1234, 0, "R1 not");
    // R2 add with and without carry
    issue(1, 4, 16'hFFFF, 1, 0, "R2 add carry");
    issue(1, 4, 16'h1234, 16'h0101, 0, "R2 add");
    // R3 sub borrow, equal, normal
    issue(1, 5, 3, 5, 0, "R3 sub borrow");
    issue(1, 5, 5, 5, 0, "R3 sub equal");
    issue(1, 5, 5, 3, 0, "R3 sub");
    // R4 multiplies
    issue(1, 6, 16'h0100, 16'h0100, 0, "R4 mull ovf");
    issue(1, 6, 16'h00FF, 16'h00FF, 0, "R4 mull fit");
    issue(1, 7, 16'hFFFF, 16'hFFFF, 0, "R4 umulh");
    // R5 signed high multiply
    issue(1, 8, 16'hFFFF, 16'hFFFF, 0, "R5 smulh -1*-1");
    issue(1, 8, 16'h4000, 2, 0, "R5 smulh ovf");
    issue(1, 8, 16'h8000, 1, 0, "R5 smulh min");
    issue(1, 8, 16'h8000, 16'hFFFF, 0, "R5 smulh min*-1");
    // R6 shifts, amounts 0, mid, W-1, W, large
    issue(1, 9, 16'h8001, 0, 0, "R6 shl 0");
    issue(1, 9, 16'h0F01, 3, 0, "R6 shl 3");
    issue(1, 9, 16'h0001, 15, 0, "R6 shl 15");
    issue(1, 9, 16'hFFFF, 16, 0, "R6 shl W");
    issue(1, 10, 16'h8001, 15, 0, "R6 shr 15");
    issue(1, 10, 16'hF0F0, 4, 0, "R6 shr 4");
    issue(1, 10, 16'hFFFE, 16'hFFFF, 0, "R6 shr large");
    // R7 compares, signed vs unsigned disagreement
    issue(1, 11, 7, 7, 0, "R7 cmpe");
    issue(1, 12, 16'h8000, 1, 0, "R7 cmpa");
    issue(1, 13, 1, 1, 0, "R7 cmpae");
    issue(1, 14, 16'h8000, 1, 0, "R7 cmpg");
    issue(1, 15, 16'hFFFF, 16'hFFFF, 0, "R7 cmpge");
    // R8 flag set then cmov back to back, both polarities
    issue(1, 11, 2, 2, 0, "R8 set flag");
    issue(1, 17, 0, 16'hAAAA, 16'h5555, "R8 cmov taken");
    issue(1, 11, 1, 2, 0, "R8 clear flag");
    issue(1, 17, 0, 16'hAAAA, 16'h5555, "R8 cmov kept");
    issue(1, 16, 0, 16'h1357, 16'h5555, "R8 mov");
    // R9 idle strobe does not load the flag
    issue(1, 11, 9, 9, 0, "R9 set flag");
    issue(0, 4, 1, 1, 0, "R9 idle add");
    issue(1, 16, 0, 16'h0042, 0, "R9 flag held");
    // R10 unused opcodes
    issue(1, 18, 16'hFFFF, 16'hFFFF, 0, "R10 op18");
    issue(1, 31, 16'h1234, 16'h4321, 0, "R10 op31");
    issue(0, 16, 0, 16'h7777, 0, "R10 idle mov");
    // sweep of all opcodes with pseudo-random operands
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [15:0] jv, av;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      jv = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      av = (k % 3 == 0) ? {12'h0, lfsr[3:0]} : lfsr;
      issue((k % 7) != 0, k % 20, jv, av, jv ^ av, "R10 sweep");
    end
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule